// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block is the digital control section of a one-to-ten clock fanout buffer. One of two reference clocks is routed to ten single-ended outputs. Each output either follows the chosen clock or floats at high impedance.

Software or a board controller programs the block through a three-wire port: an enable line, a shift clock and a data line. The three wires are synchronised into the system clock domain, and each rising edge of the shift clock is detected there. While the enable line is high, the first eleven shift-clock edges load a configuration word one bit at a time. The twelfth edge copies the word into a holding register, and only that register steers the outputs. A new setting therefore appears on all outputs at once. A frame that is cut short leaves the running configuration untouched.

Top module: `fanout_ctl`

## Requirements
- R1: After synchronous reset the holding register enables all ten outputs and selects reference clock 0.
- R2: Shift-clock edges seen while the enable line is low change neither the outputs nor any later frame's contents.
- R3: The first data bit of a frame becomes the enable of output 0, the second the enable of output 1, and so on up to output 9. A 1 enables the output.
- R4: The eleventh data bit of a frame picks the source clock: 0 selects reference clock 0 and 1 selects reference clock 1.
- R5: The outputs change only on the twelfth shift-clock edge of a frame. A frame of eleven edges or fewer leaves the outputs as they were.
- R6: An enabled output equals the selected reference clock combinationally. A disabled output is high impedance.
- R7: Dropping the enable line clears the edge count, so a new frame after a partial one is loaded from its own first bit.
- R8: Shift-clock edges after the twelfth, with the enable line still high, have no effect until the enable line is dropped and raised again. The edge count never passes twelve.
- R9: If the enable line falls in the same synchronised cycle as the twelfth shift-clock edge, no transfer takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Serial programming enable, active high |
| prog_sclk | input | 1 | Serial shift clock; its rising edges count |
| prog_sdi | input | 1 | Serial data, sampled on shift-clock rising edges |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| fan_out | output | 10 | Fanned-out clocks; a bit is high impedance when that output is disabled |

## Verification
Two events can land in the same system-clock cycle: the transfer edge of a frame and the fall of the enable line. The three serial wires pass through synchroniser chains of equal depth. The bench drives the twelfth shift-clock rise and the enable fall on the same system-clock edge, so both reach the sequencer together. The bench then expects the previous configuration to remain on the outputs, checked with both source clocks. A normal frame sent afterwards must still load correctly. A second coincidence lies in the output stage: a source-clock change is checked in the same settled window as a freshly transferred configuration.

// File: rtl/fo_pkg.sv
// Package: shared types and constants for the clock fanout controller.
// Assumes one configuration word of per-output enables plus one select bit.
package fo_pkg;

    // Action the frame sequencer asks for on a detected shift-clock edge
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2
    } act_e;

    // Number of fanout outputs at the default configuration
    localparam int DEF_N_OUT = 10;

endpackage

// File: rtl/fo_sync_edge.sv
// Module: fo_sync_edge
// Brings the three serial-port wires into the clk domain through chains of
// equal depth, so that bits driven together stay aligned. Flags a rising
// edge of the shift clock for exactly one clk cycle.
// Assumes the shift clock stays high and low for at least two clk periods.
module fo_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    input  logic sclk_async,
    input  logic sdi_async,
    output logic en_s,
    output logic sdi_s,
    output logic sclk_rise
);
    localparam int NW = 3;

    logic [NW-1:0] stage [SYNC_STAGES];
    logic          sclk_d;

    // Synchroniser chain: stage 0 samples the pins, later stages follow
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= {en_async, sclk_async, sdi_async};
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised shift clock, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= stage[SYNC_STAGES-1][1];
    end

    assign en_s      = stage[SYNC_STAGES-1][2];
    assign sdi_s     = stage[SYNC_STAGES-1][0];
    assign sclk_rise = stage[SYNC_STAGES-1][1] & ~sclk_d;

endmodule

// File: rtl/fo_frame_seq.sv
// Module: fo_frame_seq
// Counts qualified shift-clock edges within one enable window. It asks for
// a shift on the first WORD_W edges and a load on the next one, then
// ignores further edges. The count saturates and clears while enable is low.
module fo_frame_seq
    import fo_pkg::*;
#(
    parameter int WORD_W = 11,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             sclk_rise,
    output act_e             act,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LOAD_IDX = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(WORD_W + 1);

    // Decode the requested action from the count and the qualified edge
    always_comb begin
        act = ACT_NONE;
        if (en_s && sclk_rise) begin
            if (cnt < LOAD_IDX)       act = ACT_SHIFT;
            else if (cnt == LOAD_IDX) act = ACT_LOAD;
        end
    end

    // Edge counter: cleared while disabled, advances up to DONE_IDX
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en_s) begin
            cnt <= '0;
        end else if (sclk_rise && cnt < DONE_IDX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fo_shift_reg.sv
// Module: fo_shift_reg
// Serial-in shift register. New bits enter at the top and move down, so the
// first bit of a frame ends in position 0 after WORD_W shifts.
// Keeps its contents whenever no shift is requested.
module fo_shift_reg
    import fo_pkg::*;
#(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word
);
    // Shift one bit in on each requested shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (act == ACT_SHIFT) begin
            word <= {sdi_s, word[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/fo_ctrl_reg.sv
// Module: fo_ctrl_reg
// Holding register that steers the outputs. It loads the whole shifted word
// at once on a load request. The reset value enables every output and
// selects reference clock 0.
module fo_ctrl_reg
    import fo_pkg::*;
#(
    parameter int N_OUT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic [N_OUT:0]   word,
    output logic [N_OUT-1:0] oe,
    output logic             sel
);
    // Load the shifted word on the transfer edge, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe  <= '1;
            sel <= 1'b0;
        end else if (act == ACT_LOAD) begin
            oe  <= word[N_OUT-1:0];
            sel <= word[N_OUT];
        end
    end

endmodule

// File: rtl/fo_drive.sv
// Module: fo_drive
// Output stage: a two-input clock multiplexer feeding N_OUT tri-state
// drivers. It is purely combinational, so the outputs follow the source
// clock with no register in the path.
module fo_drive #(
    parameter int N_OUT = 10
) (
    input  logic             ref_clk0,
    input  logic             ref_clk1,
    input  logic             sel,
    input  logic [N_OUT-1:0] oe,
    output logic [N_OUT-1:0] fan_out
);
    logic src_clk;

    // Source clock multiplexer
    assign src_clk = sel ? ref_clk1 : ref_clk0;

    // One tri-state driver per output
    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_drv
            assign fan_out[i] = oe[i] ? src_clk : 1'bz;
        end
    endgenerate

endmodule

// File: rtl/fanout_ctl.sv
// Module: fanout_ctl (top)
// Serial-programmed controller for a one-to-N_OUT clock fanout. It chains
// the synchroniser, the frame sequencer, the shift register, the holding
// register and the output stage.
// Assumes the serial wires change slowly against clk.
module fanout_ctl
    import fo_pkg::*;
#(
    parameter int N_OUT       = DEF_N_OUT,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             prog_sclk,
    input  logic             prog_sdi,
    input  logic             ref_clk0,
    input  logic             ref_clk1,
    output logic [N_OUT-1:0] fan_out
);
    localparam int WORD_W = N_OUT + 1;

    logic             en_s;
    logic             sdi_s;
    logic             sclk_rise;
    act_e             act;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] sr_word;
    logic [N_OUT-1:0] cfg_oe;
    logic             cfg_sel;

    fo_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .en_async(prog_en), .sclk_async(prog_sclk), .sdi_async(prog_sdi),
        .en_s(en_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
    );

    fo_frame_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .sclk_rise(sclk_rise),
        .act(act), .cnt(cnt)
    );

    fo_shift_reg #(.WORD_W(WORD_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .act(act), .sdi_s(sdi_s), .word(sr_word)
    );

    fo_ctrl_reg #(.N_OUT(N_OUT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .act(act), .word(sr_word),
        .oe(cfg_oe), .sel(cfg_sel)
    );

    fo_drive #(.N_OUT(N_OUT)) u_drv (
        .ref_clk0(ref_clk0), .ref_clk1(ref_clk1), .sel(cfg_sel),
        .oe(cfg_oe), .fan_out(fan_out)
    );

endmodule

// File: rtl/fanout_ctl_chk.sv
// Module: fanout_ctl_chk
// Property checker bound into fanout_ctl. It watches the sequencer count,
// the requested action, the shift register and the holding register.
module fanout_ctl_chk #(
    parameter int N_OUT = 10,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_s,
    input logic [1:0]       act,
    input logic [CNT_W-1:0] cnt,
    input logic [N_OUT:0]   sr_word,
    input logic [N_OUT-1:0] cfg_oe,
    input logic             cfg_sel
);
    localparam logic [1:0] A_LOAD = 2'd2;

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> (cfg_oe == '1 && cfg_sel == 1'b0)); // R1

    AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(sr_word)); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        act != A_LOAD |=> ($stable(cfg_oe) && $stable(cfg_sel))); // R5

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> cnt == '0); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(N_OUT + 2)); // R8

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        act == A_LOAD |=> act != A_LOAD); // R8

    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> act != A_LOAD); // R9

endmodule

bind fanout_ctl fanout_ctl_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .act(act), .cnt(cnt),
    .sr_word(sr_word), .cfg_oe(cfg_oe), .cfg_sel(cfg_sel)
);

// File: tb/fanout_ctl_tb.sv
// Bench for fanout_ctl: sweeps configuration words and checks the outputs
// against values computed from the requirements.
module fanout_ctl_tb;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic r0 = 1'b0, r1 = 1'b1;
    wire  [N-1:0] fan_out;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    fanout_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(en), .prog_sclk(sclk),
        .prog_sdi(sdi), .ref_clk0(r0), .ref_clk1(r1), .fan_out(fan_out)
    );

    always #10 clk = ~clk; // 50 MHz

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One shift-clock pulse carrying bit b
    task automatic pulse(input logic b);
        sdi = b; wclk(3);
        sclk = 1'b1; wclk(3);
        sclk = 1'b0;
    endtask

    // Compare outputs with word w (bits 0..9 enables, bit 10 select)
    task automatic check_word(input logic [N:0] w, input string req);
        for (int k = 0; k < 2; k++) begin
            logic [N-1:0] exp;
            logic src;
            r0 = k[0]; r1 = ~k[0];
            wclk(1);
            src = w[N] ? r1 : r0;
            for (int i = 0; i < N; i++) exp[i] = w[i] ? src : 1'bz;
            n_run++;
            if (fan_out !== exp) begin
                n_fail++;
                $display("FAIL %s: fan_out=%b expected=%b", req, fan_out, exp);
            end
        end
    endtask

    // Complete frame: eleven data bits first-to-last, then the transfer pulse
    task automatic frame(input logic [N:0] w, input int extra);
        en = 1'b1; wclk(3);
        for (int i = 0; i <= N; i++) pulse(w[i]);
        pulse(1'b0);
        for (int i = 0; i < extra; i++) pulse(~w[i % (N+1)]);
        wclk(6);
        en = 1'b0; wclk(6);
    endtask

    initial begin
        logic [N:0] cur;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        cur = {1'b0, {N{1'b1}}};
        check_word(cur, "R1 reset state");

        // R2: pulses with enable low have no effect
        for (int i = 0; i < 14; i++) pulse(1'b0);
        wclk(6);
        check_word(cur, "R2 pulses while disabled");

        // R3/R4/R6: one-hot enables with each select
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin
                cur = '0; cur[i] = 1'b1; cur[N] = s[0];
                frame(cur, 0);
                check_word(cur, "R3 R4 R6 one-hot");
            end

        // R3/R4/R6 sweep over the word space
        for (int w = 0; w < 2048; w += 7) begin
            cur = w[N:0];
            frame(cur, 0);
            check_word(cur, "R3 R4 R6 sweep");
        end

        // R5: eleven pulses only, no transfer
        en = 1'b1; wclk(3);
        for (int i = 0; i <= N; i++) pulse(~cur[i]);
        wclk(6);
        check_word(cur, "R5 no transfer before edge twelve");
        en = 1'b0; wclk(6);
        check_word(cur, "R5 partial frame discarded");

        // R7: partial frame, drop enable, then a full frame loads aligned
        en = 1'b1; wclk(3);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        en = 1'b0; wclk(6);
        cur = 11'b101_0011_0110;
        frame(cur, 0);
        check_word(cur, "R7 count cleared by enable low");

        // R8: extra pulses after the transfer do nothing
        cur = 11'b010_1100_1001;
        frame(cur, 14);
        check_word(cur, "R8 pulses after transfer ignored");

        // R9: enable falls together with the twelfth rise
        en = 1'b1; wclk(3);
        for (int i = 0; i <= N; i++) pulse(~cur[i]);
        sdi = 1'b0; wclk(3);
        sclk = 1'b1; en = 1'b0; wclk(3);
        sclk = 1'b0; wclk(8);
        check_word(cur, "R9 coincident enable fall blocks transfer");
        cur = 11'b111_1111_0000;
        frame(cur, 0);
        check_word(cur, "R9 next frame still loads");

        // R1 again: reset restores the default
        rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(2);
        check_word({1'b0, {N{1'b1}}}, "R1 reset after programming");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule